// File: doc/BRIEF.md
# Wired-OR Priority Arbitration Among Bus Devices

This block settles which of several bus devices gets the bus. No single arbiter picks the winner. Each device has a fixed four-bit identity code. When arbitration is launched, every device that wants the bus drives its code onto a shared group of four lines. Those lines behave as a wired-OR: a line reads 1 if any device drives it.

Each device watches the lines from the most significant one downwards. At the first line that reads 1 where its own code has a 0, the device stops driving that bit and every bit below it. It recomputes this every cycle from what it currently sees. The lines then converge to the largest code among the requesters.

A start pulse, accepted only while idle, takes a snapshot of the request inputs and opens a settling window of fixed length. When the window closes, the device whose code equals the settled line value raises its win flag, and a one-cycle done pulse marks the result as valid. The flags hold until the next accepted start. Codes are inputs, held stable and unique by the system.

Top module: `idarb_top`

## Requirements
- R1: While reset is asserted and after it is released, `lines_o`, `busy_o`, `done_o` and every bit of `win_o` are 0 until the first accepted start.
- R2: A start pulse seen on a clock edge while `busy_o` is low is accepted. `busy_o` is then high for exactly SETTLE cycles beginning the next cycle. `done_o` is high for exactly one cycle, the first cycle after `busy_o` falls.
- R3: A start pulse while `busy_o` is high is ignored. It changes neither the window length nor the set of participants nor the result.
- R4: The set of participants is the value of `req_i` on the accepting edge. Later changes of `req_i` during the window have no effect on the lines or the result.
- R5: Device i takes its code from `ids_i[4*i+3:4*i]`. `lines_o` is the bitwise OR of all device drives, and bit 3 is the most significant line. A non-participant never drives. Whenever `busy_o` is low, `lines_o` is 0.
- R6: On the accepting edge, each participant starts driving its full code. On each later window edge except the last, it drives its own code with bit b and all bits below b cleared. Here b is the highest bit where the current lines read 1 and its own code reads 0; with no such bit, it drives its full code. Line 3 therefore stays constant throughout a window.
- R7: With SETTLE at least 4, `lines_o` in the last cycle of the window equals the largest code among the participants, or 0 with no participant.
- R8: On the closing edge, a participant's win flag is set exactly when its code equals the lines value in that last window cycle; all other flags are cleared. At most one flag is high. Flags hold until the next accepted start, which clears them.
- R9: With no participant, the lines stay 0 for the whole window, `done_o` still pulses, and no win flag rises. A lone participant with code 0 does win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches an arbitration round when idle |
| req_i | input | NDEV | Per-device request, sampled at launch |
| ids_i | input | NDEV*4 | Per-device four-bit code, device i at bits 4i+3..4i |
| lines_o | output | 4 | Current value of the wired-OR arbitration lines |
| busy_o | output | 1 | Settling window in progress |
| done_o | output | 1 | One-cycle pulse: win flags just became valid |
| win_o | output | NDEV | Per-device win flag |

## Verification
The bench builds the block with NDEV = 16 and SETTLE = 4. With 16 devices, the code assignment is a permutation of all sixteen codes. That brings code 0 as a lone winner and code 15 as an overriding one within reach. A window of 4 is the shortest that still lets four lines settle, so any extra settling step or off-by-one in the window shows up as a wrong final line value. Request patterns are chosen so that lower lines flip back and forth while higher lines resolve. A shift-register pattern generator adds mixed request sets. Starts and request changes issued in the middle of a window probe the launch snapshot.

// File: rtl/idarb_pkg.sv
package idarb_pkg;

  localparam int ARB_W = 4;

  typedef logic [ARB_W-1:0] arb_code_t;

  // Bits of own code still driven after looking at the lines: the highest
  // position where a line is 1 against an own 0 drops itself and everything below.
  function automatic arb_code_t keep_bits(arb_code_t own, arb_code_t seen);
    arb_code_t keep;
    logic      lost;
    lost = 1'b0;
    for (int b = ARB_W - 1; b >= 0; b--) begin
      lost    = lost | (seen[b] & ~own[b]);
      keep[b] = ~lost;
    end
    return own & keep;
  endfunction

  function automatic logic is_winner(logic joined, arb_code_t own, arb_code_t seen);
    return joined && (own == seen);
  endfunction

endpackage

// File: rtl/idarb_window.sv
module idarb_window #(
  parameter int SETTLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic done_o
);
  localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SETTLE - 1);

  logic             busy_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o = start_i & ~busy_q;
  assign last_o = busy_q & (cnt_q == CNT_END);
  assign step_o = busy_q & ~last_o;
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= last_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (last_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (step_o) begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/idarb_cell.sv
module idarb_cell
  import idarb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  arb_code_t id_i,
  input  logic      req_i,
  input  arb_code_t lines_i,
  input  logic      load_i,
  input  logic      step_i,
  input  logic      last_i,
  output arb_code_t drv_o,
  output logic      win_o
);
  arb_code_t drv_q;
  logic      part_q;
  logic      win_q;

  assign drv_o = drv_q;
  assign win_o = win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q  <= '0;
      part_q <= 1'b0;
      win_q  <= 1'b0;
    end else if (load_i) begin
      part_q <= req_i;
      drv_q  <= req_i ? id_i : '0;
      win_q  <= 1'b0;
    end else if (last_i) begin
      win_q  <= is_winner(part_q, id_i, lines_i);
      drv_q  <= '0;
      part_q <= 1'b0;
    end else if (step_i) begin
      drv_q  <= part_q ? keep_bits(id_i, lines_i) : '0;
    end
  end
endmodule

// File: rtl/idarb_wor.sv
module idarb_wor
  import idarb_pkg::*;
#(
  parameter int NDEV = 8
) (
  input  logic [NDEV*ARB_W-1:0] drv_i,
  output arb_code_t             lines_o
);
  always_comb begin
    lines_o = '0;
    for (int i = 0; i < NDEV; i++) begin
      lines_o = lines_o | drv_i[i*ARB_W +: ARB_W];
    end
  end
endmodule

// File: rtl/idarb_top.sv
module idarb_top
  import idarb_pkg::*;
#(
  parameter int NDEV   = 8,
  parameter int SETTLE = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [NDEV-1:0]       req_i,
  input  logic [NDEV*ARB_W-1:0] ids_i,
  output logic [ARB_W-1:0]      lines_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [NDEV-1:0]       win_o
);
  logic                  load_w;
  logic                  step_w;
  logic                  last_w;
  logic [NDEV*ARB_W-1:0] drv_w;
  arb_code_t             lines_w;

  idarb_window #(.SETTLE(SETTLE)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .load_o  (load_w),
    .step_o  (step_w),
    .last_o  (last_w),
    .done_o  (done_o)
  );

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    idarb_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .id_i    (ids_i[g*ARB_W +: ARB_W]),
      .req_i   (req_i[g]),
      .lines_i (lines_w),
      .load_i  (load_w),
      .step_i  (step_w),
      .last_i  (last_w),
      .drv_o   (drv_w[g*ARB_W +: ARB_W]),
      .win_o   (win_o[g])
    );
  end

  idarb_wor #(.NDEV(NDEV)) u_wor (
    .drv_i   (drv_w),
    .lines_o (lines_w)
  );

  assign lines_o = lines_w;
endmodule

// File: rtl/idarb_chk.sv
module idarb_chk
  import idarb_pkg::*;
#(
  parameter int NDEV   = 8,
  parameter int SETTLE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [NDEV-1:0]  win_o,
  input arb_code_t        lines_o,
  input logic             last_w
);
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 0;
    else        run_q <= busy_o ? run_q + 1 : 0;
  end

  // R8
  win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_o));

  // R2
  done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R2
  done_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(busy_o) && !busy_o));

  // R2
  launch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R2
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_q == SETTLE));

  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_w) |=> busy_o);

  // R5
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (lines_o == '0));

  // R6
  top_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (lines_o[ARB_W-1] == $past(lines_o[ARB_W-1])));

  // R8
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && !$rose(busy_o)) |-> $stable(win_o));
endmodule

bind idarb_top idarb_chk #(.NDEV(NDEV), .SETTLE(SETTLE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .win_o   (win_o),
  .lines_o (lines_o),
  .last_w  (last_w)
);

// File: tb/idarb_top_test.sv
`timescale 1ns/100ps
module idarb_top_test;
  localparam int NDEV   = 16;
  localparam int SETTLE = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [NDEV-1:0]   req_i = '0;
  logic [NDEV*4-1:0] ids_i;
  logic [3:0]        lines_o;
  logic              busy_o;
  logic              done_o;
  logic [NDEV-1:0]   win_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  idarb_top #(.NDEV(NDEV), .SETTLE(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_i(req_i), .ids_i(ids_i),
    .lines_o(lines_o), .busy_o(busy_o), .done_o(done_o), .win_o(win_o)
  );

  int code [NDEV];
  initial for (int i = 0; i < NDEV; i++) begin
    code[i] = (7 * i + 3) % 16;
    ids_i[i*4 +: 4] = 4'(code[i]);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, behavioural
  bit              m_busy, m_done;
  int              m_cnt;
  bit              m_part [NDEV];
  int              m_drv  [NDEV];
  logic [NDEV-1:0] m_win;

  function automatic int m_lines();
    int v = 0;
    for (int i = 0; i < NDEV; i++) v |= m_drv[i];
    return v;
  endfunction

  function automatic int back_off(int own, int seen);
    for (int b = 3; b >= 0; b--)
      if (seen[b] && !own[b]) return (own >> (b + 1)) << (b + 1);
    return own;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_win = '0;
      for (int i = 0; i < NDEV; i++) begin m_part[i] = 0; m_drv[i] = 0; end
    end else begin
      int seen;
      seen = m_lines();
      m_done = 0;
      if (start_i && !m_busy) begin
        m_busy = 1; m_cnt = 0; m_win = '0;
        for (int i = 0; i < NDEV; i++) begin
          m_part[i] = req_i[i];
          m_drv[i]  = req_i[i] ? code[i] : 0;
        end
      end else if (m_busy) begin
        if (m_cnt == SETTLE - 1) begin
          m_busy = 0; m_done = 1;
          for (int i = 0; i < NDEV; i++) begin
            m_win[i]  = m_part[i] && (seen == code[i]);
            m_drv[i]  = 0;
            m_part[i] = 0;
          end
        end else begin
          m_cnt++;
          for (int i = 0; i < NDEV; i++)
            m_drv[i] = m_part[i] ? back_off(code[i], seen) : 0;
        end
      end
    end
  end

  // cycle compare away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(lines_o == 4'(m_lines()), "R6 lines per cycle", lines_o, m_lines());
      check(busy_o == m_busy, "R2 busy", busy_o, m_busy);
      check(done_o == m_done, "R2 done", done_o, m_done);
      check(win_o == m_win, "R8 win flags", win_o, m_win);
    end
  end

  function automatic int best_of(logic [NDEV-1:0] mask);
    int b = -1;
    for (int i = 0; i < NDEV; i++) if (mask[i] && code[i] > b) b = code[i];
    return b;
  endfunction

  function automatic logic [NDEV-1:0] win_for(logic [NDEV-1:0] mask);
    logic [NDEV-1:0] w = '0;
    int b = best_of(mask);
    for (int i = 0; i < NDEV; i++) if (mask[i] && code[i] == b) w[i] = 1'b1;
    return w;
  endfunction

  // one round; disturb=1 pulses start again and scrambles req mid-window (R3, R4)
  task automatic round(input logic [NDEV-1:0] mask, input bit disturb);
    int b;
    b = best_of(mask);
    @(negedge clk); req_i = mask; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    if (disturb) begin req_i = ~mask; start_i = 1'b1; end
    @(negedge clk); start_i = 1'b0;
    if (disturb) req_i = mask ^ 16'h5A5A;
    repeat (SETTLE - 2) @(negedge clk);
    check(busy_o == 1'b1, "R2 busy in last window cycle", busy_o, 1);
    check(lines_o == 4'((b < 0) ? 0 : b), "R7 settled lines", lines_o, (b < 0) ? 0 : b);
    @(negedge clk);
    check(done_o == 1'b1, "R2 done pulse", done_o, 1);
    check(win_o == win_for(mask), disturb ? "R3 R4 winner after disturbance" : "R8 winner",
          win_o, win_for(mask));
    check(lines_o == 4'h0, "R5 lines released", lines_o, 0);
    if (mask == '0) check(win_o == '0, "R9 no requester", win_o, 0);
    @(negedge clk);
    check(win_o == win_for(mask), "R8 flags held", win_o, win_for(mask));
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1
    check(lines_o == 0 && busy_o == 0 && done_o == 0 && win_o == 0,
          "R1 reset outputs", {lines_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(win_o == 0 && busy_o == 0, "R1 after release", win_o, 0);

    round(16'h0010, 0);           // lone code 15
    round(16'h0800, 0);           // R9 lone code 0 wins
    round(16'h0000, 0);           // R9 nobody
    round(16'hFFFF, 0);
    round(16'h00F0, 0);
    round(16'hAAAA, 0);
    round(16'h0C0C, 0);
    round(16'h1234, 1);           // R3 R4
    round(16'h0000, 1);           // R3 R4 with no requesters
    lfsr = 16'hACE1;
    for (int k = 0; k < 10; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      round(lfsr & {lfsr[7:0], lfsr[15:8]}, k % 3 == 0);
    end
    // R8 clear on next accepted start
    @(negedge clk); req_i = 16'h0001; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(win_o == 0, "R8 flags cleared at start", win_o, 0);
    repeat (SETTLE + 2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule